// File: doc/BRIEF.md
# Double-Word Transfer Sequencer for a 32-Bit Memory Port

This block carries out 64-bit floating-point register loads and stores over a data port that moves only 32 bits at a time. A request supplies a base address value, a signed 16-bit displacement, a direction flag (load or store), 64 bits of store data and two endianness controls. The block forms the effective address and rejects it if it is not double-word aligned. Otherwise it runs two ordered word transactions on a request/acknowledge memory port. It either joins the two returned words into one 64-bit result or splits the store data across the two writes.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` raised while busy has no effect, and the requester must hold it until it sees ready. The completion side has no back-pressure. `done` (after either kind of transfer) and `addr_err` (after a rejected request) are single-cycle pulses, and `rd_data` is valid alongside `done` after a load. The address is used as a physical address.

Top module: `fp_dword_seq`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to the address width, taken modulo 2^AW.
- R2: A request whose effective address has any of bits [2:0] set raises `addr_err` for exactly one cycle, the cycle after acceptance. It issues no memory transaction and produces no `done`.
- R3: An aligned request issues exactly two word transactions: the first at the effective address, the second at the effective address plus 4 (modulo 2^AW).
- R4: The active byte order is `cfg_big_endian` XOR `rev_endian`, sampled when the request is accepted (1 = big-endian).
- R5: On a big-endian load, the word from the lower address becomes `rd_data[63:32]` and the word from the higher address becomes `rd_data[31:0]`. On a little-endian load, the halves are swapped.
- R6: On a big-endian store, `req_wdata[63:32]` is written first at the lower address and `req_wdata[31:0]` second at the higher address. On a little-endian store, `req_wdata[31:0]` goes to the lower address and `req_wdata[63:32]` to the higher address. `mem_we` is 1 for stores and 0 for loads.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values. The sequencer moves to the next word, or finishes, only on a cycle in which `mem_ack` is sampled high.
- R8: `done` pulses for one cycle, the cycle after the second acknowledge. After a load, `rd_data` changes only at that point. A store leaves `rd_data` unchanged.
- R9: `req_ready` is low from acceptance of an aligned request until the cycle `done` is high. `req_valid` during that time starts no extra transaction.
- R10: Synchronous active-high `rst` returns the sequencer to idle. `mem_req`, `done` and `addr_err` go low, `req_ready` goes high, and an interrupted transfer never reports `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_big_endian | input | 1 | Configured byte order, 1 = big-endian |
| rev_endian | input | 1 | Run-time byte-order inversion |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this edge if valid |
| req_store | input | 1 | 1 = store, 0 = load |
| req_base | input | AW | Base address value |
| req_offset | input | OFS_W | Signed displacement |
| req_wdata | input | 2*WORD_W | Store data |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | AW | Word transaction address |
| mem_wdata | output | WORD_W | Write word |
| mem_ack | input | 1 | Transaction completes this edge |
| mem_rdata | input | WORD_W | Read word, valid with `mem_ack` |
| done | output | 1 | Transfer finished (one cycle) |
| rd_data | output | 2*WORD_W | Assembled load result |
| addr_err | output | 1 | Misaligned request rejected (one cycle) |

## Verification
The bench builds the block with AW = 16, the same width as the displacement. This puts wrap-around of the address sum at 0xFFFF and large negative displacements within reach of small base values, and it keeps the model memory a 64-word array aliased over the address space. WORD_W stays at 32, so the lane mapping runs on the real 32/64-bit split. The bench sets a per-request acknowledge latency of zero to two wait states, which exercises the hold behaviour on both words.

// File: rtl/fp_dword_pkg.sv
package fp_dword_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_state_t;
endpackage

// File: rtl/fp_dword_ea.sv
module fp_dword_ea #(
  parameter int AW         = 32,
  parameter int OFS_W      = 16,
  parameter int ALIGN_BITS = 3
) (
  input  logic [AW-1:0]    base,
  input  logic [OFS_W-1:0] offset,
  output logic [AW-1:0]    ea,
  output logic             misaligned
);
  logic [AW+OFS_W-1:0] ofs_wide;

  // sign-extend far enough, then keep the low AW bits
  assign ofs_wide   = {{AW{offset[OFS_W-1]}}, offset};
  assign ea         = base + ofs_wide[AW-1:0];
  assign misaligned = |ea[ALIGN_BITS-1:0];
endmodule

// File: rtl/fp_dword_lanes.sv
module fp_dword_lanes #(
  parameter int WORD_W = 32,
  localparam int DW    = 2 * WORD_W
) (
  input  logic              big_end,
  input  logic              second_phase,
  input  logic [DW-1:0]     st_data,
  input  logic [WORD_W-1:0] first_word,
  input  logic [WORD_W-1:0] second_word,
  output logic [WORD_W-1:0] wr_word,
  output logic [DW-1:0]     ld_data
);
  logic [WORD_W-1:0] upper_half, lower_half;

  assign upper_half = st_data[DW-1:WORD_W];
  assign lower_half = st_data[WORD_W-1:0];

  // big-endian sends the upper half first; little-endian the lower half
  assign wr_word = (big_end ^ second_phase) ? upper_half : lower_half;
  assign ld_data = big_end ? {first_word, second_word} : {second_word, first_word};
endmodule

// File: rtl/fp_dword_seq.sv
module fp_dword_seq
  import fp_dword_pkg::*;
#(
  parameter int AW     = 32,
  parameter int OFS_W  = 16,
  parameter int WORD_W = 32,
  localparam int DW         = 2 * WORD_W,
  localparam int ALIGN_BITS = $clog2(DW / 8),
  localparam int STEP       = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_big_endian,
  input  logic              rev_endian,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [AW-1:0]     req_base,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [DW-1:0]     req_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  output logic              addr_err
);
  seq_state_t        state_q;
  logic [AW-1:0]     ea_q;
  logic              big_q;
  logic              store_q;
  logic [DW-1:0]     wdata_q;
  logic [WORD_W-1:0] first_q;

  logic [AW-1:0]     ea_now;
  logic              misaligned;
  logic              accept;
  logic              busy;
  logic              in_second;
  logic [WORD_W-1:0] lane_wr;
  logic [DW-1:0]     lane_ld;

  fp_dword_ea #(
    .AW(AW), .OFS_W(OFS_W), .ALIGN_BITS(ALIGN_BITS)
  ) u_ea (
    .base       (req_base),
    .offset     (req_offset),
    .ea         (ea_now),
    .misaligned (misaligned)
  );

  fp_dword_lanes #(.WORD_W(WORD_W)) u_lanes (
    .big_end      (big_q),
    .second_phase (in_second),
    .st_data      (wdata_q),
    .first_word   (first_q),
    .second_word  (mem_rdata),
    .wr_word      (lane_wr),
    .ld_data      (lane_ld)
  );

  assign busy      = (state_q != ST_IDLE);
  assign in_second = (state_q == ST_SECOND);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  assign mem_req   = busy;
  assign mem_we    = busy && store_q;
  assign mem_addr  = in_second ? ea_q + AW'(STEP) : ea_q;
  assign mem_wdata = (busy && store_q) ? lane_wr : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ea_q     <= '0;
      big_q    <= 1'b0;
      store_q  <= 1'b0;
      wdata_q  <= '0;
      first_q  <= '0;
      done     <= 1'b0;
      addr_err <= 1'b0;
      rd_data  <= '0;
    end else begin
      done     <= 1'b0;
      addr_err <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (misaligned) begin
              addr_err <= 1'b1;
            end else begin
              state_q <= ST_FIRST;
              ea_q    <= ea_now;
              big_q   <= cfg_big_endian ^ rev_endian;
              store_q <= req_store;
              wdata_q <= req_wdata;
            end
          end
        end
        ST_FIRST: begin
          if (mem_ack) begin
            first_q <= mem_rdata;
            state_q <= ST_SECOND;
          end
        end
        ST_SECOND: begin
          if (mem_ack) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
            if (!store_q) rd_data <= lane_ld;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fp_dword_chk.sv
module fp_dword_chk #(
  parameter int AW     = 32,
  parameter int WORD_W = 32,
  localparam int STEP  = WORD_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [WORD_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              done,
  input logic              addr_err
);
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_second_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (!mem_req || (mem_addr == $past(mem_addr) + AW'(STEP))));

  p_aligned_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (mem_addr[2:0] == 3'd0));

  p_err_no_bus_r2: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (!mem_req && !done));

  p_err_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> !addr_err);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  p_reset_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mem_req && !done && !addr_err && req_ready));
endmodule

bind fp_dword_seq fp_dword_chk #(.AW(AW), .WORD_W(WORD_W)) u_fp_dword_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .done      (done),
  .addr_err  (addr_err)
);

// File: tb/test_fp_dword_seq.sv
module test_fp_dword_seq;
  localparam int AW = 16;

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] ofs;
    logic        st;
    logic [63:0] wd;
    logic        be;
    logic        rev;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{16'h0010, 16'h0000, 1'b0, 64'h0, 1'b1, 1'b0, 2'd0},
    '{16'h0010, 16'h0000, 1'b0, 64'h0, 1'b0, 1'b0, 2'd1},
    '{16'h0040, 16'hFFF8, 1'b0, 64'h0, 1'b1, 1'b1, 2'd2},
    '{16'h0020, 16'h0008, 1'b1, 64'h1122334455667788, 1'b1, 1'b0, 2'd0},
    '{16'h0020, 16'h0008, 1'b0, 64'h0, 1'b1, 1'b0, 2'd1},
    '{16'h0030, 16'h0000, 1'b1, 64'hAABBCCDDEEFF0099, 1'b0, 1'b1, 2'd1},
    '{16'h0030, 16'h0000, 1'b0, 64'h0, 1'b0, 1'b0, 2'd0},
    '{16'h0011, 16'h0000, 1'b0, 64'h0, 1'b1, 1'b0, 2'd0},
    '{16'h0010, 16'h0004, 1'b1, 64'hDEADBEEFCAFEF00D, 1'b1, 1'b0, 2'd0},
    '{16'hFFFC, 16'h000C, 1'b0, 64'h0, 1'b1, 1'b0, 2'd0},
    '{16'h0008, 16'h7FF8, 1'b0, 64'h0, 1'b1, 1'b1, 2'd1},
    '{16'h0003, 16'h0005, 1'b1, 64'h0123456789ABCDEF, 1'b0, 1'b0, 2'd2}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_big_endian, rev_endian;
  logic        req_valid, req_ready, req_store;
  logic [15:0] req_base, req_offset;
  logic [63:0] req_wdata;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        done, addr_err;
  logic [63:0] rd_data;

  always #2 clk = ~clk;

  fp_dword_seq #(.AW(AW), .OFS_W(16), .WORD_W(32)) i_fp_dword_seq (
    .clk(clk), .rst(rst), .cfg_big_endian(cfg_big_endian), .rev_endian(rev_endian),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .rd_data(rd_data), .addr_err(addr_err)
  );

  // model memory, 64 words aliased over the address space
  logic [31:0] mem [64];
  logic [15:0] log_a [8];
  logic        log_we [8];
  logic [31:0] log_wd [8];
  int          log_total;
  int          wcnt;
  int          cur_lat;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE0000 | (i * 32'h00000111);
      mem_ack   = 1'b0;
      mem_rdata = '0;
      wcnt      = 0;
      log_total = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt    = 0;
    end else if (mem_req) begin
      if (wcnt == cur_lat) begin
        mem_ack   = 1'b1;
        mem_rdata = mem[mem_addr[7:2]];
        log_a[log_total % 8]  = mem_addr;
        log_we[log_total % 8] = mem_we;
        log_wd[log_total % 8] = mem_wdata;
        if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
        log_total = log_total + 1;
      end else begin
        wcnt = wcnt + 1;
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    finish_run();
  end

  // issue one request and wait for its completion pulse
  task automatic issue(input vec_t v, output bit got_done, output bit got_err,
                       output logic [63:0] got_rd, output int start);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    start          = log_total;
    cur_lat        = int'(v.lat);
    cfg_big_endian = v.be;
    rev_endian     = v.rev;
    req_store      = v.st;
    req_base       = v.base;
    req_offset     = v.ofs;
    req_wdata      = v.wd;
    req_valid      = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_done  = 1'b0;
    got_err   = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (done || addr_err) break;
      @(negedge clk);
    end
    got_done = done;
    got_err  = addr_err;
    got_rd   = rd_data;
    @(negedge clk);
    chk(!done && !addr_err, "R8 pulse width", {62'd0, done, addr_err}, 64'd0);
  endtask

  initial begin
    bit          gd, ge;
    logic [63:0] grd, prev_rd, exp_rd;
    int          st;
    logic [15:0] ea, ea2;
    logic        eff, unal;
    logic [31:0] w0, w1, exp_first, exp_second;

    rst = 1'b1; req_valid = 1'b0; req_store = 1'b0; req_base = '0; req_offset = '0;
    req_wdata = '0; cfg_big_endian = 1'b1; rev_endian = 1'b0; cur_lat = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(req_ready && !mem_req && !done && !addr_err && rd_data == 64'd0, "R10 reset state",
        {59'd0, req_ready, mem_req, done, addr_err, |rd_data}, 64'h10);

    for (int k = 0; k < NV; k++) begin
      ea   = VEC[k].base + VEC[k].ofs;           // R1 with AW equal to offset width
      ea2  = ea + 16'd4;
      unal = (ea[2:0] != 3'd0);
      eff  = VEC[k].be ^ VEC[k].rev;             // R4
      w0   = mem[ea[7:2]];
      w1   = mem[ea2[7:2]];
      prev_rd = rd_data;
      issue(VEC[k], gd, ge, grd, st);
      if (unal) begin
        chk(ge && !gd, "R2 misaligned error", {62'd0, gd, ge}, 64'd1);
        chk(log_total == st, "R2 no transaction", 64'(log_total - st), 64'd0);
      end else begin
        chk(gd && !ge, "R8 done", {62'd0, gd, ge}, 64'd2);
        chk(log_total - st == 2, "R3 two transactions", 64'(log_total - st), 64'd2);
        chk(log_a[st % 8] == ea, "R1 R3 first address", 64'(log_a[st % 8]), 64'(ea));
        chk(log_a[(st + 1) % 8] == ea2, "R3 second address", 64'(log_a[(st + 1) % 8]), 64'(ea2));
        chk(log_we[st % 8] == VEC[k].st && log_we[(st + 1) % 8] == VEC[k].st, "R6 write enable",
            {62'd0, log_we[st % 8], log_we[(st + 1) % 8]}, {62'd0, VEC[k].st, VEC[k].st});
        if (VEC[k].st) begin
          exp_first  = eff ? VEC[k].wd[63:32] : VEC[k].wd[31:0];
          exp_second = eff ? VEC[k].wd[31:0]  : VEC[k].wd[63:32];
          chk(log_wd[st % 8] == exp_first && log_wd[(st + 1) % 8] == exp_second, "R6 R4 store split",
              {log_wd[st % 8], log_wd[(st + 1) % 8]}, {exp_first, exp_second});
          chk(grd == prev_rd, "R8 store keeps rd_data", grd, prev_rd);
        end else begin
          exp_rd = eff ? {w0, w1} : {w1, w0};
          chk(grd == exp_rd, "R5 R4 load assembly", grd, exp_rd);
        end
      end
    end

    // R9 and R8: request held while busy is ignored, result appears only with done
    begin
      vec_t v;
      v = '{16'h0018, 16'h0000, 1'b0, 64'h0, 1'b1, 1'b0, 2'd2};
      prev_rd = rd_data;
      @(negedge clk);
      st = log_total;
      cur_lat = 2;
      cfg_big_endian = 1'b1; rev_endian = 1'b0;
      req_store = 1'b0; req_base = v.base; req_offset = v.ofs; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_base = 16'h0028;
      for (int c = 0; c < 40; c++) begin
        if (done) break;
        chk(!req_ready, "R9 ready low while busy", {63'd0, req_ready}, 64'd0);
        chk(rd_data == prev_rd, "R8 rd_data stable before done", rd_data, prev_rd);
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk(done && req_ready, "R9 ready back with done", {62'd0, done, req_ready}, 64'd3);
      chk(rd_data == {mem[6], mem[7]}, "R5 load after busy", rd_data, {mem[6], mem[7]});
      repeat (3) @(negedge clk);
      chk(log_total - st == 2, "R9 no extra transaction", 64'(log_total - st), 64'd2);
    end

    // R10 reset in the middle of a transfer
    @(negedge clk);
    cur_lat = 2;
    req_base = 16'h0020; req_offset = 16'h0000; req_store = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_req, "R10 transfer started", {63'd0, mem_req}, 64'd1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!mem_req && req_ready && !done && !addr_err, "R10 reset mid transfer",
        {60'd0, mem_req, req_ready, done, addr_err}, 64'h4);
    begin
      bit seen;
      seen = 1'b0;
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (done || mem_req) seen = 1'b1;
      end
      chk(!seen, "R10 no done after reset", {63'd0, seen}, 64'd0);
    end

    finish_run();
  end
endmodule